// File: doc/BRIEF.md
# SPI Master with Direction-Level Preamble

This block is a mode-0 SPI master for a half-duplex slave that decides whether a transaction is a read or a write from the level on MOSI at the moment chip select is asserted. Before any clock edge, the master drives the direction level on MOSI: high for a write, low for a read. It then pulls the active-low select down and keeps the level steady for a minimum number of system clock cycles. Only after that does it clock the data bytes.

The user side issues a command through a valid/ready pair. A command carries the direction, the number of bytes minus one, and the SCLK half-period in system clock cycles. For writes, the block pulls each byte from a data port and signals each pull with a one-cycle take strobe. For reads, it returns each assembled byte with a one-cycle valid strobe. In the gap between bytes, MOSI keeps the last bit it sent and never falls back to a default zero. When the last byte is done, SCLK rests low and select is released half a period later, together with a done pulse.

Top module: `spi_dirstrobe_master`

## Requirements
- R1: While reset is applied and after it is removed, the select output is high, SCLK is low, MOSI is low and req_ready is high.
- R2: For a write command (req_write=1), MOSI is high for at least one half-period (the effective divider, cycles) before the select falls, and it is high in the first cycle the select is low.
- R3: For a read command (req_write=0), MOSI is low before the select falls and stays low for the whole time the select is low.
- R4: After the select falls, MOSI does not change for HOLD_CYCLES system clock cycles.
- R5: SCLK is low whenever the select is high. Each high and low SCLK phase lasts the effective divider in cycles, where the effective divider is req_div, or 1 when req_div is 0. A transaction of N bytes produces exactly 8*N rising edges.
- R6: A write sends req_len+1 bytes. Each byte is taken from wr_data in the cycle wr_take is high and is sent MSB first. The first bit is valid before the first rising edge, and later bits change only on falling edges.
- R7: After the eighth falling edge of a byte, MOSI keeps that byte's last bit for at least one half-period, until the next byte is loaded or the select is released.
- R8: A read samples MISO on rising SCLK edges, MSB first, and presents each byte on rd_data with a one-cycle rd_valid pulse. rd_valid never pulses during a write.
- R9: One half-period after the final falling edge, the select returns high. done pulses once in that same cycle, with SCLK low and req_ready high.
- R10: req_valid is ignored while req_ready is low. A request made during a transaction changes neither that transaction nor starts another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LEN_W | Byte count minus one |
| req_div | input | DIV_W | SCLK half-period in clk cycles (0 acts as 1) |
| req_ready | output | 1 | High when idle and able to accept a command |
| wr_data | input | 8 | Next write byte |
| wr_take | output | 1 | wr_data is consumed at this clock edge |
| rd_data | output | 8 | Last received byte |
| rd_valid | output | 1 | One-cycle strobe: rd_data holds a new byte |
| done | output | 1 | One-cycle strobe at the end of a transaction |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Master data out and direction level |
| miso | input | 1 | Slave data in |
| cs_n | output | 1 | Active-low slave select |

## Verification
The assertions assume that a slave changes MISO only away from the rising SCLK edges. They also assume that req_write is sampled only when a request is accepted, so the direction level latched by the checker is the one in force. The bench slave model updates MISO one half-cycle after each falling SCLK edge that it detects, and it changes wr_data only at falling clk edges. Requests made while the block is busy deliberately carry a different direction and length, so that any leak would show up in the captured traffic.

// File: rtl/spi_ds_pkg.sv
package spi_ds_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HOLD,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_TAIL
    } ds_state_e;

    typedef struct packed {
        logic                 wr;
        logic [BIT_IDX_W-1:0] bit_idx;
    } ds_ctl_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spi_ds_timer.sv
module spi_ds_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] period,
    output logic         fire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= period - W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign fire = (cnt == '0);
endmodule

// File: rtl/spi_ds_shifter.sv
module spi_ds_shifter
    import spi_ds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              tx_adv,
    input  logic              rx_en,
    input  logic              rx_bit,
    output logic              tx_next,
    output logic [BYTE_W-1:0] rx_byte
);
    logic [BYTE_W-1:0] tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_val;
        end else if (tx_adv) begin
            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte <= '0;
        end else if (rx_en) begin
            rx_byte <= {rx_byte[BYTE_W-2:0], rx_bit};
        end
    end

    // bit that follows the one currently on the line
    assign tx_next = tx_q[BYTE_W-2];
endmodule

// File: rtl/spi_dirstrobe_master.sv
module spi_dirstrobe_master
    import spi_ds_pkg::*;
#(
    parameter int DIV_W       = 4,
    parameter int LEN_W       = 4,
    parameter int HOLD_CYCLES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DIV_W-1:0]  req_div,
    output logic              req_ready,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              wr_take,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
    localparam int TMR_W  = max_int(DIV_W, HOLD_W);

    ds_state_e         state;
    ds_ctl_t           ctl;
    logic [LEN_W-1:0]  left_q;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  div_in;
    logic [TMR_W-1:0]  period;
    logic              fire;
    logic              restart;
    logic              accept;
    logic              load_byte;
    logic              tx_adv;
    logic              rx_en;
    logic              tx_next;
    logic              last_bit;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign div_in    = (req_div == '0) ? DIV_W'(1) : req_div;
    assign last_bit  = (ctl.bit_idx == BIT_IDX_W'(BYTE_W - 1));

    // every state change restarts the phase timer
    assign restart   = accept || ((state != ST_IDLE) && fire);
    assign load_byte = fire && ((state == ST_HOLD) || (state == ST_GAP));
    assign wr_take   = load_byte && ctl.wr;
    assign rx_en     = fire && (state == ST_LOW);
    assign tx_adv    = fire && (state == ST_HIGH) && !last_bit;

    always_comb begin
        unique case (state)
            ST_IDLE:  period = TMR_W'(div_in);
            ST_SETUP: period = TMR_W'(HOLD_CYCLES);
            default:  period = TMR_W'(div_q);
        endcase
    end

    spi_ds_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .period  (period),
        .fire    (fire)
    );

    spi_ds_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load_byte),
        .load_val (ctl.wr ? wr_data : '0),
        .tx_adv   (tx_adv),
        .rx_en    (rx_en),
        .rx_bit   (miso),
        .tx_next  (tx_next),
        .rx_byte  (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ctl      <= '0;
            left_q   <= '0;
            div_q    <= DIV_W'(1);
            cs_n     <= 1'b1;
            sclk     <= 1'b0;
            mosi     <= 1'b0;
            rd_valid <= 1'b0;
            done     <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            done     <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        ctl.wr <= req_write;
                        left_q <= req_len;
                        div_q  <= div_in;
                        mosi   <= req_write;
                        state  <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (fire) begin
                        cs_n  <= 1'b0;
                        state <= ST_HOLD;
                    end
                end
                ST_HOLD, ST_GAP: begin
                    if (fire) begin
                        mosi        <= ctl.wr & wr_data[BYTE_W-1];
                        ctl.bit_idx <= '0;
                        state       <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (fire) begin
                        sclk  <= 1'b1;
                        state <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (fire) begin
                        sclk <= 1'b0;
                        if (!last_bit) begin
                            ctl.bit_idx <= ctl.bit_idx + BIT_IDX_W'(1);
                            mosi        <= ctl.wr & tx_next;
                            state       <= ST_LOW;
                        end else begin
                            rd_valid <= !ctl.wr;
                            if (left_q != '0) begin
                                left_q <= left_q - LEN_W'(1);
                                state  <= ST_GAP;
                            end else begin
                                state <= ST_TAIL;
                            end
                        end
                    end
                end
                ST_TAIL: begin
                    if (fire) begin
                        cs_n  <= 1'b1;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_ds_checker.sv
module spi_ds_checker #(
    parameter int HOLD_CYCLES = 5
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_write,
    input logic req_ready,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic rd_valid,
    input logic done
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);

    logic          dir_q;
    logic [HW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= 1'b0;
            low_cnt <= '0;
        end else begin
            if (req_valid && req_ready) dir_q <= req_write;
            if (cs_n) low_cnt <= '0;
            else if (low_cnt != HW'(HOLD_CYCLES)) low_cnt <= low_cnt + HW'(1);
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (cs_n && !sclk && !mosi && req_ready));

    p_dir_level_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (mosi == dir_q));

    p_read_low_r3: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !dir_q) |-> !mosi);

    p_hold_window_r4: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && (low_cnt < HW'(HOLD_CYCLES))) |-> $stable(mosi));

    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    p_rd_in_read_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (!dir_q && !cs_n));

    p_done_end_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && !sclk && req_ready));

    p_release_done_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> done);

    p_ready_idle_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> cs_n);
endmodule

bind spi_dirstrobe_master spi_ds_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .mosi      (mosi),
    .rd_valid  (rd_valid),
    .done      (done)
);

// File: tb/spi_dirstrobe_master_tb.sv
module spi_dirstrobe_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 5;
    localparam int NVEC = 7;
    // {write, len[2:0], div[3:0], seed[7:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1, 3'd0, 4'd1, 8'hA5},
        {1'b0, 3'd1, 4'd2, 8'h3C},
        {1'b1, 3'd2, 4'd3, 8'h81},
        {1'b0, 3'd0, 4'd1, 8'h00},
        {1'b1, 3'd1, 4'd4, 8'hFF},
        {1'b1, 3'd1, 4'd2, 8'h00},
        {1'b0, 3'd0, 4'd0, 8'h96}
    };

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0, miso = 0;
    logic [3:0] req_len = 0, req_div = 0;
    logic [7:0] wr_data = 0;
    logic req_ready, wr_take, rd_valid, done, sclk, mosi, cs_n;
    logic [7:0] rd_data;

    spi_dirstrobe_master #(.DIV_W(4), .LEN_W(4), .HOLD_CYCLES(HOLD)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_len(req_len), .req_div(req_div), .req_ready(req_ready),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data),
        .rd_valid(rd_valid), .done(done), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [7:0] cur_seed = 0;
    int cs_falls, rises, dones, rdn, wr_idx, hold_viol, gap_viol, rd_mosi_hi;
    int setup_cnt, dir_setup, hold_cnt, gap_cnt, done_bad;
    logic dir_seen, gap_act, gap_bit, take_seen;
    logic prev_cs, prev_sclk, prev_mosi;
    logic [7:0] m_shift, s_shift;
    logic [7:0] cap [16];
    logic [7:0] rcap [16];

    function automatic logic [7:0] wbyte(input logic [7:0] s, input int i);
        return s + 8'(i * 37);
    endfunction
    function automatic logic [7:0] rbyte(input logic [7:0] s, input int i);
        return s ^ 8'(i * 91) ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // sampling and slave model, all at the falling clk edge
    always @(negedge clk) begin
        if (rst) begin
            prev_cs = 1; prev_sclk = 0; prev_mosi = 0; setup_cnt = 0;
            gap_act = 0; take_seen = 0;
        end else begin
            if (take_seen) wr_idx++;
            take_seen = wr_take;
            wr_data = wbyte(cur_seed, wr_idx);
            if (prev_cs && !cs_n) begin
                cs_falls++; dir_seen = mosi; dir_setup = setup_cnt; hold_cnt = 0;
                s_shift = rbyte(cur_seed, 0); miso = s_shift[7];
            end else if (!cs_n) begin
                hold_cnt++;
                if (mosi != prev_mosi && hold_cnt < HOLD) hold_viol++;
                if (!dir_seen && mosi) rd_mosi_hi++;
            end
            if (cs_n) setup_cnt = (mosi == prev_mosi) ? setup_cnt + 1 : 1;
            if (gap_act && (mosi != gap_bit || cs_n || sclk)) begin
                if (gap_cnt < int'(req_div == 0 ? 4'd1 : req_div)) gap_viol++;
                gap_act = 0;
            end
            if (gap_act) gap_cnt++;
            if (!prev_sclk && sclk) begin
                m_shift = {m_shift[6:0], mosi};
                rises++;
                if (rises % 8 == 0) cap[(rises/8 - 1) % 16] = m_shift;
            end
            if (prev_sclk && !sclk) begin
                if (rises % 8 == 0) begin
                    gap_act = 1; gap_bit = mosi; gap_cnt = 1;
                    s_shift = rbyte(cur_seed, rises / 8);
                end else begin
                    s_shift = {s_shift[6:0], 1'b0};
                end
                miso = s_shift[7];
            end
            if (rd_valid) begin rcap[rdn % 16] = rd_data; rdn++; end
            if (done) begin dones++; if (!cs_n || sclk || !req_ready) done_bad++; end
            prev_cs = cs_n; prev_sclk = sclk; prev_mosi = mosi;
        end
    end

    task automatic clear_stats(input logic [7:0] seed);
        cur_seed = seed; cs_falls = 0; rises = 0; dones = 0; rdn = 0; wr_idx = 0;
        hold_viol = 0; gap_viol = 0; rd_mosi_hi = 0; done_bad = 0;
    endtask

    task automatic wait_done();
        while (dones == 0) begin @(negedge clk); #1; end
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic verify(input bit wr, input int nb, input int div);
        check(cs_falls == 1, "R10", cs_falls, 1);
        check(dir_seen == wr, wr ? "R2" : "R3", dir_seen, wr);
        if (wr) check(dir_setup >= div, "R2", dir_setup, div);
        else check(rd_mosi_hi == 0, "R3", rd_mosi_hi, 0);
        check(hold_viol == 0, "R4", hold_viol, 0);
        check(rises == 8 * nb, "R5", rises, 8 * nb);
        check(gap_viol == 0, "R7", gap_viol, 0);
        check(dones == 1 && done_bad == 0, "R9", dones, 1);
        if (wr) begin
            check(rdn == 0, "R8", rdn, 0);
            check(wr_idx == nb, "R6", wr_idx, nb);
            for (int i = 0; i < nb; i++)
                check(cap[i] == wbyte(cur_seed, i), "R6", cap[i], wbyte(cur_seed, i));
        end else begin
            check(rdn == nb, "R8", rdn, nb);
            for (int i = 0; i < nb; i++)
                check(rcap[i] == rbyte(cur_seed, i), "R8", rcap[i], rbyte(cur_seed, i));
        end
    endtask

    task automatic issue(input bit wr, input logic [3:0] len, input logic [3:0] div);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_len = len; req_div = div;
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset levels
        check(cs_n && !sclk && !mosi && req_ready, "R1", {cs_n, sclk, mosi, req_ready}, 4'b1001);
        rst = 0;
        @(negedge clk); #1;
        check(cs_n && !sclk && !mosi && req_ready, "R1", {cs_n, sclk, mosi, req_ready}, 4'b1001);

        for (int v = 0; v < NVEC; v++) begin
            automatic bit wr = VEC[v][15];
            automatic int nb = int'(VEC[v][14:12]) + 1;
            automatic int dv = (VEC[v][11:8] == 0) ? 1 : int'(VEC[v][11:8]);
            clear_stats(VEC[v][7:0]);
            issue(wr, {1'b0, VEC[v][14:12]}, VEC[v][11:8]);
            wait_done();
            verify(wr, nb, dv);
        end

        // R10: requests while busy are ignored
        clear_stats(8'h6B);
        issue(1'b1, 4'd1, 4'd2);
        req_div = 4'd2;
        repeat (6) @(negedge clk);
        req_valid = 1; req_write = 0; req_len = 4'd3;
        repeat (20) @(negedge clk);
        req_valid = 0; req_div = 4'd2;
        wait_done();
        verify(1'b1, 2, 2);
        check(req_ready && cs_n, "R10", {req_ready, cs_n}, 2'b11);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule